// File: doc/BRIEF.md
# Interleaved Block Protection Engine

This block handles per-block integrity data on a byte stream. The stream is cut into fixed intervals of `BLK_BYTES` data bytes. On the protected side each interval is followed at once by an 8-byte trailer: a CRC guard, an application tag and a reference tag. The engine works in one of three modes, picked by a configuration input:

- **Generate:** it appends a freshly computed trailer after each interval.
- **Remove:** it checks each incoming trailer and drops it from the output.
- **Forward:** it checks each incoming trailer and passes it on untouched.

Configuration supplies the CRC seed, the expected application tag, the starting reference tag and a mask that picks which trailer fields are compared. Both stream sides use valid/ready handshakes. Checking failures are reported as a one-cycle pulse carrying the failing fields and the interval number. The stream keeps flowing after an error.

Top module: `prot_engine`

## Requirements
- R1: After reset, `out_valid` and `err_valid` are low, the first interval has index 0, and its reference tag equals `cfg_ref_seed`.
- R2: With `cfg_mode`=0 (generate), each interval is output as its `BLK_BYTES` data bytes followed by 8 trailer bytes. Bytes 0-1 are the guard, bytes 2-3 the application tag (`cfg_app_tag`) and bytes 4-7 the reference tag, each field sent most significant byte first. No input byte is accepted while trailer bytes are being output.
- R3: The guard is a CRC-16 over the interval's data bytes. It uses polynomial 0x8BB7, processes each byte MSB first, has no reflection and no final XOR, and restarts from `cfg_guard_seed` at every interval.
- R4: The reference tag of interval n is `cfg_ref_seed` + n (modulo 2^32).
- R5: With `cfg_mode`=1 (remove), data bytes are forwarded and the 8 trailer bytes are consumed without appearing on the output.
- R6: With `cfg_mode`=2 (forward), every input byte, trailer bytes included, appears unchanged and in order on the output.
- R7: In remove and forward modes, a mismatch in a checked field raises `err_valid` for exactly one cycle, in the cycle after the last trailer byte of that interval is accepted. `err_field` then reports the failing fields: bit 0 is the guard, bit 1 the application tag, bit 2 the reference tag. `err_index` holds the interval number, counted from 0 after reset.
- R8: A field whose bit in `cfg_chk_mask` is 0 (same bit order as `err_field`) never causes an error and never appears in `err_field`. A mask of 0 disables all reporting.
- R9: Backpressure on `out_ready` loses and duplicates no byte. While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged, given a source that holds its byte.
- R10: After an error, later intervals are still processed and checked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_mode | input | 2 | 0 generate, 1 remove, 2 forward |
| cfg_guard_seed | input | 16 | CRC start value for each interval |
| cfg_app_tag | input | 16 | Application tag to emit or expect |
| cfg_ref_seed | input | 32 | Reference tag of interval 0 |
| cfg_chk_mask | input | 3 | Field compare enables {ref, app, guard} |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine accepts input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Sink accepts output byte |
| err_valid | output | 1 | One-cycle error pulse |
| err_field | output | 3 | Failing fields {ref, app, guard} |
| err_index | output | 32 | Interval number of the failure |

## Verification
The assertions assume the configuration inputs do not change between reset and the end of a run. They also assume the source keeps `in_valid` high and `in_data` steady until its byte is accepted, because the forwarding paths pass both straight through. The bench sets every configuration value before releasing reset and leaves it alone until the next reset. Its source drops `in_valid` only while no byte is pending, and it stalls the sink with a cycle pattern that varies from test to test.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    MODE_GEN    = 2'd0,
    MODE_REMOVE = 2'd1,
    MODE_FWD    = 2'd2
  } prot_mode_e;

  localparam int unsigned TRL_BYTES = 8;
  localparam logic [15:0] GUARD_POLY = 16'h8BB7;

  // One byte of CRC-16, MSB first, no reflection.
  function automatic logic [15:0] crc16_byte(input logic [15:0] cur,
                                             input logic [7:0] b,
                                             input logic [15:0] poly);
    logic [15:0] c;
    logic fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
    end
    return c;
  endfunction

  // Trailer byte k: guard, app tag, ref tag, MSB first.
  function automatic logic [7:0] trl_byte(input logic [63:0] tup,
                                          input logic [2:0] k);
    return tup[8*(7 - int'(k)) +: 8];
  endfunction

  // Field flag that trailer byte k belongs to.
  function automatic logic [2:0] field_of(input logic [2:0] k);
    if (k < 3'd2) return 3'b001;
    else if (k < 3'd4) return 3'b010;
    else return 3'b100;
  endfunction

endpackage

// File: rtl/prot_crc16.sv
module prot_crc16
  import prot_pkg::*;
#(
  parameter logic [15:0] POLY = GUARD_POLY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] seed,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic        fresh;
  logic [15:0] acc;

  assign crc = fresh ? seed : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh <= 1'b1;
      acc   <= '0;
    end else if (clr) begin
      fresh <= 1'b1;
    end else if (en) begin
      acc   <= crc16_byte(crc, din, POLY);
      fresh <= 1'b0;
    end
  end

  assert_clr_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == seed));
endmodule

// File: rtl/prot_chk.sv
module prot_chk
  import prot_pkg::*;
#(
  parameter int unsigned IDX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             last,
  input  logic [2:0]       k,
  input  logic [7:0]       rx,
  input  logic [63:0]      exp_tup,
  input  logic [2:0]       mask,
  input  logic [IDX_W-1:0] idx,
  output logic             err_valid,
  output logic [2:0]       err_field,
  output logic [IDX_W-1:0] err_index
);
  logic [2:0] mis;
  logic [2:0] mis_nxt;
  logic [2:0] hit;

  assign mis_nxt = mis | ((rx != trl_byte(exp_tup, k)) ? field_of(k) : 3'b000);
  assign hit     = mis_nxt & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mis       <= '0;
      err_valid <= 1'b0;
      err_field <= '0;
      err_index <= '0;
    end else begin
      err_valid <= 1'b0;
      if (en) begin
        if (last) begin
          mis       <= '0;
          err_valid <= |hit;
          err_field <= hit;
          err_index <= idx;
        end else begin
          mis <= mis_nxt;
        end
      end
    end
  end

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);
  assert_err_has_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_field != 3'b000));
  assert_err_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> ((err_field & ~mask) == 3'b000));
endmodule

// File: rtl/prot_engine.sv
module prot_engine
  import prot_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_mode,
  input  logic [15:0] cfg_guard_seed,
  input  logic [15:0] cfg_app_tag,
  input  logic [31:0] cfg_ref_seed,
  input  logic [2:0]  cfg_chk_mask,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  output logic        err_valid,
  output logic [2:0]  err_field,
  output logic [31:0] err_index
);
  localparam int unsigned SPAN  = BLK_BYTES + TRL_BYTES;
  localparam int unsigned POS_W = $clog2(SPAN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SPAN - 1);
  localparam logic [POS_W-1:0] POS_TRL  = POS_W'(BLK_BYTES);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] trl_off;
  logic [31:0]      idx;
  logic [15:0]      guard;
  logic [63:0]      tup;
  logic [2:0]       k;
  logic             in_trl, is_gen, is_rem;
  logic             in_fire, out_fire;
  logic             step, step_data, step_chk, wrap;

  assign is_gen  = (cfg_mode == MODE_GEN);
  assign is_rem  = (cfg_mode == MODE_REMOVE);
  assign in_trl  = (pos >= POS_TRL);
  assign trl_off = pos - POS_TRL;
  assign k       = trl_off[2:0];
  assign tup     = {guard, cfg_app_tag, cfg_ref_seed + idx};

  always_comb begin
    if (in_trl && is_gen) begin
      in_ready  = 1'b0;
      out_valid = 1'b1;
      out_data  = trl_byte(tup, k);
    end else if (in_trl && is_rem) begin
      in_ready  = 1'b1;
      out_valid = 1'b0;
      out_data  = in_data;
    end else begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_data  = in_data;
    end
  end

  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign step      = (in_trl && is_gen) ? out_fire : in_fire;
  assign step_data = step && !in_trl;
  assign step_chk  = step && in_trl && !is_gen;
  assign wrap      = step && (pos == POS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      idx <= '0;
    end else if (step) begin
      if (wrap) begin
        pos <= '0;
        idx <= idx + 32'd1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  prot_crc16 #(.POLY(GUARD_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (cfg_guard_seed),
    .clr   (wrap),
    .en    (step_data),
    .din   (in_data),
    .crc   (guard)
  );

  prot_chk #(.IDX_W(32)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (step_chk),
    .last      (wrap),
    .k         (k),
    .rx        (in_data),
    .exp_tup   (tup),
    .mask      (cfg_chk_mask),
    .idx       (idx),
    .err_valid (err_valid),
    .err_field (err_field),
    .err_index (err_index)
  );

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_LAST);
  assert_gen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_gen && in_trl && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_remove_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rem && in_trl) |-> !out_valid);
  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (idx == $past(idx) + 32'd1));
  assert_gen_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_gen && in_trl) |-> !in_fire);
endmodule

// File: tb/prot_engine_tb.sv
module prot_engine_tb;
  localparam int PERIOD = 10;
  localparam int BLK = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [15:0] cfg_guard_seed = 16'h0;
  logic [15:0] cfg_app_tag = 16'h0;
  logic [31:0] cfg_ref_seed = 32'h0;
  logic [2:0]  cfg_chk_mask = 3'b111;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        err_valid;
  logic [2:0]  err_field;
  logic [31:0] err_index;

  int total = 0;
  int bad = 0;
  bit done = 0;

  byte unsigned src[$];
  byte unsigned exp_q[$];
  byte unsigned got[$];
  int err_idx_q[$];
  int err_fld_q[$];
  int stall_bad;

  always #(PERIOD/2) clk = ~clk;

  prot_engine #(.BLK_BYTES(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_guard_seed(cfg_guard_seed), .cfg_app_tag(cfg_app_tag),
    .cfg_ref_seed(cfg_ref_seed), .cfg_chk_mask(cfg_chk_mask),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .err_valid(err_valid), .err_field(err_field), .err_index(err_index)
  );

  function automatic logic [15:0] m_crc(input logic [15:0] s, input logic [7:0] b);
    logic [15:0] c;
    c = s ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ 16'h8BB7) : (c << 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [15:0] gs,
                          input logic [15:0] at, input logic [31:0] rs,
                          input logic [2:0] mk);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    cfg_mode = m; cfg_guard_seed = gs; cfg_app_tag = at;
    cfg_ref_seed = rs; cfg_chk_mask = mk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    src.delete(); exp_q.delete(); got.delete();
    err_idx_q.delete(); err_fld_q.delete();
  endtask

  // Build intervals. corrupt[i] = field flags to spoil in interval i.
  task automatic build(input int n, input bit with_trl, input int salt,
                       input logic [2:0] corrupt[4], input bit keep_trl_out);
    logic [15:0] g;
    logic [63:0] t;
    for (int i = 0; i < n; i++) begin
      g = cfg_guard_seed;
      for (int j = 0; j < BLK; j++) begin
        byte unsigned d;
        d = byte'((i * 37 + j * 11 + salt) & 8'hFF);
        g = m_crc(g, d);
        src.push_back(d);
        exp_q.push_back(d);
      end
      t = {g, cfg_app_tag, cfg_ref_seed + 32'(i)};
      if (corrupt[i][0]) t[63:48] = t[63:48] ^ 16'h0100;
      if (corrupt[i][1]) t[47:32] = t[47:32] ^ 16'h0001;
      if (corrupt[i][2]) t[31:0]  = t[31:0] ^ 32'h8000_0000;
      for (int b = 0; b < 8; b++) begin
        byte unsigned tb;
        tb = t[63 - 8*b -: 8];
        if (with_trl) src.push_back(tb);
        if (keep_trl_out) exp_q.push_back(tb);
      end
    end
  endtask

  task automatic run(input int vmod, input int rmod);
    int sidx = 0;
    int idle = 0;
    bit pend = 0;
    bit prev_stall = 0;
    logic [7:0] prev_d = 8'h0;
    stall_bad = 0;
    for (int cyc = 1; cyc < 20000 && idle < 30; cyc++) begin
      @(negedge clk);
      if (!pend) pend = (sidx < src.size()) && (vmod == 0 || (cyc % vmod) != 0);
      in_valid = pend;
      in_data = pend ? src[sidx] : 8'h00;
      out_ready = (rmod == 0) || ((cyc % rmod) != 0);
      #(PERIOD/2 - 1);
      if (prev_stall && out_valid && out_data != prev_d) stall_bad++;
      if (prev_stall && !out_valid) stall_bad++;
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      if (in_valid && in_ready) begin sidx++; pend = 0; end
      if (out_valid && out_ready) got.push_back(out_data);
      if (err_valid) begin
        err_idx_q.push_back(int'(err_index));
        err_fld_q.push_back(int'(err_field));
      end
      if (sidx >= src.size() && !out_valid) idle++; else idle = 0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(sidx == src.size(), "R9", "all input consumed", sidx, src.size());
  endtask

  task automatic cmp_stream(input string req);
    int first = -1;
    chk(got.size() == exp_q.size(), req, "output byte count", got.size(), exp_q.size());
    for (int i = 0; i < got.size() && i < exp_q.size(); i++)
      if (first < 0 && got[i] != exp_q[i]) first = i;
    if (first >= 0) chk(0, req, "byte mismatch", got[first], exp_q[first]);
    else chk(1, req, "bytes", 0, 0);
    chk(stall_bad == 0, "R9", "stall stability", stall_bad, 0);
  endtask

  task automatic t_reset();
    logic [2:0] cz[4] = '{3'b0, 3'b0, 3'b0, 3'b0};
    do_reset(2'd0, 16'h0000, 16'h0, 32'h0, 3'b111);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(err_valid == 1'b0, "R1", "err_valid after reset", err_valid, 0);
    // First generated interval carries ref = seed (index 0).
    do_reset(2'd0, 16'h0000, 16'h0, 32'h0000_0042, 3'b111);
    build(1, 1'b0, 1, cz, 1'b1);
    run(0, 0);
    chk(got.size() == BLK + 8 && got[BLK+7] == 8'h42, "R1", "first ref tag byte",
        got.size() == BLK + 8 ? got[BLK+7] : 0, 8'h42);
  endtask

  task automatic t_gen();
    logic [2:0] cz[4] = '{3'b0, 3'b0, 3'b0, 3'b0};
    do_reset(2'd0, 16'hFFFF, 16'hA5C3, 32'hFFFF_FFFE, 3'b111);
    build(3, 1'b0, 5, cz, 1'b1);
    run(3, 4);
    cmp_stream("R2 R3 R4");
    chk(err_idx_q.size() == 0, "R2", "no error in generate", err_idx_q.size(), 0);
  endtask

  task automatic t_remove();
    logic [2:0] cz[4] = '{3'b000, 3'b100, 3'b000, 3'b000};
    do_reset(2'd1, 16'h1234, 16'h0BAD, 32'h0000_1000, 3'b111);
    build(3, 1'b1, 9, cz, 1'b0);
    run(5, 3);
    cmp_stream("R5");
    chk(err_idx_q.size() == 1, "R7", "remove error count", err_idx_q.size(), 1);
    if (err_idx_q.size() == 1) begin
      chk(err_idx_q[0] == 1, "R7", "remove error index", err_idx_q[0], 1);
      chk(err_fld_q[0] == 4, "R7", "remove error field", err_fld_q[0], 4);
    end
  endtask

  task automatic t_forward();
    logic [2:0] cz[4] = '{3'b001, 3'b000, 3'b010, 3'b000};
    do_reset(2'd2, 16'h0000, 16'h7777, 32'h0000_0010, 3'b111);
    build(4, 1'b1, 3, cz, 1'b1);
    run(0, 2);
    cmp_stream("R6");
    chk(err_idx_q.size() == 2, "R10", "errors keep coming", err_idx_q.size(), 2);
    if (err_idx_q.size() == 2) begin
      chk(err_idx_q[0] == 0 && err_fld_q[0] == 1, "R7", "guard error idx0",
          err_fld_q[0], 1);
      chk(err_idx_q[1] == 2 && err_fld_q[1] == 2, "R10", "app error idx2",
          err_fld_q[1], 2);
    end
  endtask

  task automatic t_mask();
    logic [2:0] cz[4] = '{3'b010, 3'b101, 3'b111, 3'b000};
    do_reset(2'd2, 16'hBEEF, 16'h0001, 32'h0, 3'b101);
    build(3, 1'b1, 7, cz, 1'b1);
    run(4, 0);
    cmp_stream("R8");
    chk(err_idx_q.size() == 2, "R8", "masked error count", err_idx_q.size(), 2);
    if (err_idx_q.size() == 2) begin
      chk(err_idx_q[0] == 1 && err_fld_q[0] == 5, "R8", "idx1 fields", err_fld_q[0], 5);
      chk(err_idx_q[1] == 2 && err_fld_q[1] == 5, "R8", "idx2 app masked", err_fld_q[1], 5);
    end
    do_reset(2'd1, 16'hBEEF, 16'h0001, 32'h0, 3'b000);
    build(3, 1'b1, 7, cz, 1'b0);
    run(0, 0);
    chk(err_idx_q.size() == 0, "R8", "mask zero silences", err_idx_q.size(), 0);
  endtask

  initial begin
    t_reset();
    t_gen();
    t_remove();
    t_forward();
    t_mask();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule